// File: doc/BRIEF.md
# Multi-port serial register command interface

This block gives three serial ports access to one small register file. One port accepts writes only (the W port); the other two, command ports A and B, accept both writes and reads. All three ports sample their data line on a shared shift strobe. That strobe is derived from the master clock at full, half or quarter rate, and the rate comes from a field in register 0. A sync pulse marks the first bit of each 16-bit word. The word is shifted in MSB first: bit 15 selects write (1) or read (0), bits 14:8 carry a 7-bit register address, and bits 7:0 carry write data.

Several words can complete on the same strobe. The writes are then applied in a fixed order (W, then A, then B), so the last of them decides the stored value. A read is answered on a response line that belongs to the port that issued it. The response has its own sync pulse and starts a fixed number of strobes after the command. When A and B both read at the same moment, B's answer is queued until A's answer has gone out. Register addresses fall into three regions: writable storage, a read-only region that returns an identifier, and an unmapped gap. A read that arrives on a port whose previous response is still pending or being sent is dropped.

Top module: `sreg_cmd_hub`

## Requirements
- R1: `shift_en` is the shift strobe. Register 0 bits 1:0 set its rate: 0 gives a strobe on every clock cycle, 1 on every 2nd cycle, and 2 or 3 on every 4th cycle. The field is 0 after reset, and a new rate applies as soon as the writing word completes.
- R2: A port samples its data line only on clock edges where `shift_en` is high. Sync high on such an edge marks bit 15. The next 15 strobes supply bits 14..0. Bit 15 = 1 is a write and 0 is a read; bits 14:8 are the address and bits 7:0 the data.
- R3: A write to an address from 0 to 31 stores the 8-bit data, and a later read of that address returns it.
- R4: Writes to addresses 0x20 to 0x7F are discarded. A read of 0x60 to 0x7F returns {1'b1, address}. A read of 0x20 to 0x5F returns 0.
- R5: When writes complete on the same strobe, they apply in the order W, A, B, so the later port overrides an earlier one at the same address.
- R6: A read word on the W port has no effect: nothing is stored and no response appears on either response line.
- R7: The read response is the 16-bit word {1'b0, address, data}, sent MSB first on the port's `*_rsp_sdo`. Each bit changes just after a strobe. The response sync is high only for bit 15. That bit appears after the 11th strobe following the strobe that completed the read.
- R8: When A and B reads complete on the same strobe, B's response sync appears after the 11th strobe following the strobe on which A's response ends (16 strobes after A's sync).
- R9: A sync pulse before a word has received all 16 bits discards the partial word and starts a new one.
- R10: A read that completes on the same strobe as a write to the same address returns the value held before that write.
- R11: After reset, all registers hold 0 and both response lines and syncs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | output | 1 | Shift strobe; serial lines are sampled and driven on clock edges where it is high |
| w_sync | input | 1 | W port word sync (marks bit 15) |
| w_sdi | input | 1 | W port serial data |
| a_sync | input | 1 | Port A word sync |
| a_sdi | input | 1 | Port A serial data |
| b_sync | input | 1 | Port B word sync |
| b_sdi | input | 1 | Port B serial data |
| a_rsp_sync | output | 1 | Port A response sync, high during bit 15 of a response |
| a_rsp_sdo | output | 1 | Port A response data, MSB first |
| b_rsp_sync | output | 1 | Port B response sync |
| b_rsp_sdo | output | 1 | Port B response data, MSB first |

## Verification
Single-port writes followed by reads confirm storage and the address echo in the response. A command that sends the same address from all three ports separates a correct priority order from a reversed one. A command that pairs a write with a read shows whether reads sample before or after writes. Reads from A and B issued together show whether B is correctly queued or starts at the same time as A. Reads of the read-only and unmapped regions, a read on the W port, and a word cut short by an early sync each confirm that nothing is stored or answered when it should not be. Rate changes are checked by measuring strobe spacing and by repeating a read at the slower rates, which shows the latency is counted in strobes and not in clock cycles.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int WORD_W    = 16;
    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 8;
    localparam int NUM_PORTS = 3;
    localparam int NUM_REGS  = 32;
    localparam int RESP_LAT  = 11;
    localparam int RATE_W    = 2;
    localparam int IDX_W     = $clog2(NUM_REGS);

    localparam int PORT_W = 0;
    localparam int PORT_A = 1;
    localparam int PORT_B = 2;

    localparam logic [ADDR_W-1:0] REG_LIMIT = ADDR_W'(NUM_REGS);
    localparam logic [ADDR_W-1:0] RO_BASE   = 7'h60;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_WAIT  = 2'd1,
        RS_SHIFT = 2'd2
    } rsp_state_t;

    function automatic logic is_storage(input logic [ADDR_W-1:0] a);
        return a < REG_LIMIT;
    endfunction

    function automatic logic is_ident(input logic [ADDR_W-1:0] a);
        return a >= RO_BASE;
    endfunction

    function automatic logic [DATA_W-1:0] ident_value(input logic [ADDR_W-1:0] a);
        return {1'b1, a};
    endfunction

endpackage

// File: rtl/sreg_clkdiv.sv
module sreg_clkdiv
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + 2'd1;
    end

    always_comb begin
        case (rate)
            2'd0:    tick = 1'b1;
            2'd1:    tick = phase[0];
            default: tick = &phase;
        endcase
    end
endmodule

// File: rtl/sreg_deser.sv
module sreg_deser
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              sync,
    input  logic              sdi,
    output logic              done,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [WORD_W-2:0] shreg;
    logic [CNT_W-1:0]  nbits;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            nbits <= '0;
        end else if (tick) begin
            if (sync) begin
                shreg <= {{(WORD_W-2){1'b0}}, sdi};
                nbits <= CNT_W'(1);
            end else if (nbits != '0) begin
                shreg <= {shreg[WORD_W-3:0], sdi};
                nbits <= (nbits == CNT_W'(WORD_W-1)) ? '0 : nbits + CNT_W'(1);
            end
        end
    end

    assign done = tick && !sync && (nbits == CNT_W'(WORD_W-1));
    assign word = {shreg, sdi};
endmodule

// File: rtl/sreg_regfile.sv
module sreg_regfile
    import sreg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] wr_en,
    input  cmd_t                 wr_cmd [NUM_PORTS],
    input  logic [ADDR_W-1:0]    rd_addr_a,
    input  logic [ADDR_W-1:0]    rd_addr_b,
    output logic [DATA_W-1:0]    rd_data_a,
    output logic [DATA_W-1:0]    rd_data_b,
    output logic [RATE_W-1:0]    rate
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else begin
            // later ports override earlier ones: W, then A, then B
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (wr_en[p] && is_storage(wr_cmd[p].addr))
                    regs[wr_cmd[p].addr[IDX_W-1:0]] <= wr_cmd[p].data;
            end
        end
    end

    function automatic logic [DATA_W-1:0] lookup(input logic [ADDR_W-1:0] a);
        if (is_storage(a))    return regs[a[IDX_W-1:0]];
        else if (is_ident(a)) return ident_value(a);
        else                  return '0;
    endfunction

    assign rd_data_a = lookup(rd_addr_a);
    assign rd_data_b = lookup(rd_addr_b);
    assign rate      = regs[0][RATE_W-1:0];

    logic cfg_hit;
    always_comb begin
        cfg_hit = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (wr_en[p] && wr_cmd[p].addr == '0) cfg_hit = 1'b1;
    end

    AST_RATE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (rate != $past(rate)) |-> $past(cfg_hit)); // R1
endmodule

// File: rtl/sreg_resp.sv
module sreg_resp
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  logic              hold,
    input  logic [WORD_W-1:0] word,
    output logic              rsp_sync,
    output logic              rsp_sdo,
    output logic              busy
);
    localparam int WC_W = $clog2(RESP_LAT + 1);
    localparam int IX_W = $clog2(WORD_W);

    rsp_state_t        state;
    logic [WC_W-1:0]   wcnt;
    logic [IX_W-1:0]   idx;
    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RS_IDLE;
            wcnt  <= '0;
            idx   <= '0;
            shreg <= '0;
        end else begin
            case (state)
                RS_IDLE: if (start) begin
                    shreg <= word;
                    wcnt  <= '0;
                    state <= RS_WAIT;
                end
                RS_WAIT: if (tick && !hold) begin
                    if (wcnt == WC_W'(RESP_LAT - 1)) begin
                        idx   <= IX_W'(WORD_W - 1);
                        state <= RS_SHIFT;
                    end else begin
                        wcnt <= wcnt + WC_W'(1);
                    end
                end
                RS_SHIFT: if (tick) begin
                    if (idx == '0) begin
                        state <= RS_IDLE;
                    end else begin
                        idx   <= idx - IX_W'(1);
                        shreg <= {shreg[WORD_W-2:0], 1'b0};
                    end
                end
                default: state <= RS_IDLE;
            endcase
        end
    end

    assign rsp_sdo  = (state == RS_SHIFT) && shreg[WORD_W-1];
    assign rsp_sync = (state == RS_SHIFT) && (idx == IX_W'(WORD_W - 1));
    assign busy     = (state != RS_IDLE);

    AST_SYNC_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (rsp_sync && tick) |=> !rsp_sync); // R7
    AST_OUT_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(rsp_sync) && $stable(rsp_sdo))); // R7
endmodule

// File: rtl/sreg_cmd_hub.sv
module sreg_cmd_hub
    import sreg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic shift_en,
    input  logic w_sync,
    input  logic w_sdi,
    input  logic a_sync,
    input  logic a_sdi,
    input  logic b_sync,
    input  logic b_sdi,
    output logic a_rsp_sync,
    output logic a_rsp_sdo,
    output logic b_rsp_sync,
    output logic b_rsp_sdo
);
    logic [RATE_W-1:0]    rate;
    logic                 tick;
    logic [NUM_PORTS-1:0] sync_v, sdi_v, done_v, wr_en;
    logic [WORD_W-1:0]    words [NUM_PORTS];
    cmd_t                 cmds  [NUM_PORTS];
    logic [DATA_W-1:0]    val_a, val_b;
    logic                 rd_a, rd_b, busy_a, busy_b, hold_b;

    assign sync_v = {b_sync, a_sync, w_sync};
    assign sdi_v  = {b_sdi,  a_sdi,  w_sdi};

    sreg_clkdiv u_div (.clk(clk), .rst(rst), .rate(rate), .tick(tick));
    assign shift_en = tick;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        sreg_deser u_deser (
            .clk(clk), .rst(rst), .tick(tick),
            .sync(sync_v[p]), .sdi(sdi_v[p]),
            .done(done_v[p]), .word(words[p])
        );
        assign cmds[p]  = cmd_t'(words[p]);
        assign wr_en[p] = done_v[p] && cmds[p].wr;
    end

    // the W port carries no read path
    assign rd_a = done_v[PORT_A] && !cmds[PORT_A].wr;
    assign rd_b = done_v[PORT_B] && !cmds[PORT_B].wr;

    sreg_regfile u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cmd(cmds),
        .rd_addr_a(cmds[PORT_A].addr), .rd_addr_b(cmds[PORT_B].addr),
        .rd_data_a(val_a), .rd_data_b(val_b), .rate(rate)
    );

    assign hold_b = busy_a || rd_a;

    sreg_resp u_resp_a (
        .clk(clk), .rst(rst), .tick(tick), .start(rd_a), .hold(1'b0),
        .word({1'b0, cmds[PORT_A].addr, val_a}),
        .rsp_sync(a_rsp_sync), .rsp_sdo(a_rsp_sdo), .busy(busy_a)
    );

    sreg_resp u_resp_b (
        .clk(clk), .rst(rst), .tick(tick), .start(rd_b), .hold(hold_b),
        .word({1'b0, cmds[PORT_B].addr, val_b}),
        .rsp_sync(b_rsp_sync), .rsp_sdo(b_rsp_sdo), .busy(busy_b)
    );

    AST_B_WAITS_FOR_A: assert property (@(posedge clk) disable iff (rst)
        $rose(b_rsp_sync) |-> $past(!hold_b)); // R8
    AST_B_BUSY_WHEN_SENDING: assert property (@(posedge clk) disable iff (rst)
        b_rsp_sync |-> busy_b); // R7
endmodule

// File: tb/test_sreg_cmd_hub.sv
module test_sreg_cmd_hub;
    localparam int LAT = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic shift_en;
    logic w_sync = 0, w_sdi = 0, a_sync = 0, a_sdi = 0, b_sync = 0, b_sdi = 0;
    logic a_rsp_sync, a_rsp_sdo, b_rsp_sync, b_rsp_sdo;

    int n_tests = 0;
    int n_fail  = 0;
    int tk      = 0;
    int last_tk = 0;
    int n_resp  = 0;

    always #5 clk = ~clk;

    sreg_cmd_hub i_sreg_cmd_hub (
        .clk(clk), .rst(rst), .shift_en(shift_en),
        .w_sync(w_sync), .w_sdi(w_sdi), .a_sync(a_sync), .a_sdi(a_sdi),
        .b_sync(b_sync), .b_sdi(b_sdi),
        .a_rsp_sync(a_rsp_sync), .a_rsp_sdo(a_rsp_sdo),
        .b_rsp_sync(b_rsp_sync), .b_rsp_sdo(b_rsp_sdo)
    );

    always @(posedge clk) if (shift_en) tk <= tk + 1;

    // scoreboard queues, one set per response port
    logic [15:0] qa_v[$], qb_v[$];
    int          qa_t[$], qb_t[$];
    string       qa_r[$], qb_r[$];

    logic [7:0] mreg [32];

    function automatic logic [7:0] model_rd(input logic [6:0] a);
        if (a < 7'd32)       return mreg[a[4:0]];
        else if (a >= 7'h60) return {1'b1, a};
        else                 return 8'h00;
    endfunction

    function automatic logic [15:0] mk(input logic wr, input logic [6:0] a, input logic [7:0] d);
        return {wr, a, d};
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // monitor state per port
    int          mcol [2];
    int          mbits[2];
    int          mstart[2];
    logic [15:0] macc [2];

    task automatic finish_resp(input int p);
        logic [15:0] ev;
        int et;
        string er;
        n_resp++;
        if ((p == 0 && qa_v.size() == 0) || (p == 1 && qb_v.size() == 0)) begin
            check(0, "R6", $sformatf("unexpected response on port %0d", p), macc[p], 0);
            return;
        end
        if (p == 0) begin ev = qa_v.pop_front(); et = qa_t.pop_front(); er = qa_r.pop_front(); end
        else        begin ev = qb_v.pop_front(); et = qb_t.pop_front(); er = qb_r.pop_front(); end
        check(macc[p] == ev, er, $sformatf("port %0d response word", p), macc[p], ev);
        check(mstart[p] == et, er, $sformatf("port %0d response start strobe", p), mstart[p], et);
    endtask

    task automatic mon_step(input int p, input logic sy, input logic sd);
        if (mcol[p] == 0) begin
            if (sy) begin
                mcol[p] = 1; mbits[p] = 1; macc[p] = {15'd0, sd}; mstart[p] = tk;
            end
        end else begin
            if (sy) check(0, "R7", $sformatf("port %0d sync beyond bit 15", p), 1, 0);
            macc[p] = {macc[p][14:0], sd};
            mbits[p]++;
            if (mbits[p] == 16) begin
                mcol[p] = 0;
                finish_resp(p);
            end
        end
    endtask

    always @(negedge clk) begin
        if (!rst && tk != last_tk) begin
            mon_step(0, a_rsp_sync, a_rsp_sdo);
            mon_step(1, b_rsp_sync, b_rsp_sdo);
        end
        last_tk = tk;
    end

    task automatic drive(input logic [2:0] en, input logic [15:0] w0, input logic [15:0] w1,
                         input logic [15:0] w2, input int nbits, output int t_end);
        for (int b = 15; b >= 16 - nbits; b--) begin
            @(negedge clk);
            while (!shift_en) @(negedge clk);
            w_sync = en[0] && (b == 15); w_sdi = en[0] && w0[b];
            a_sync = en[1] && (b == 15); a_sdi = en[1] && w1[b];
            b_sync = en[2] && (b == 15); b_sdi = en[2] && w2[b];
            @(posedge clk);
        end
        @(negedge clk);
        w_sync = 0; w_sdi = 0; a_sync = 0; a_sdi = 0; b_sync = 0; b_sdi = 0;
        t_end = tk;
    endtask

    task automatic wait_strobes(input int n);
        int s;
        s = tk;
        while (tk < s + n) @(negedge clk);
    endtask

    task automatic do_cmd(input logic [2:0] en, input logic [15:0] w0, input logic [15:0] w1,
                          input logic [15:0] w2, input string req);
        int t;
        bit ra, rb;
        logic [15:0] va, vb;
        drive(en, w0, w1, w2, 16, t);
        ra = en[1] && !w1[15];
        rb = en[2] && !w2[15];
        va = {1'b0, w1[14:8], model_rd(w1[14:8])};
        vb = {1'b0, w2[14:8], model_rd(w2[14:8])};
        if (en[0] && w0[15] && w0[14:8] < 7'd32) mreg[w0[12:8]] = w0[7:0];
        if (en[1] && w1[15] && w1[14:8] < 7'd32) mreg[w1[12:8]] = w1[7:0];
        if (en[2] && w2[15] && w2[14:8] < 7'd32) mreg[w2[12:8]] = w2[7:0];
        if (ra) begin qa_v.push_back(va); qa_t.push_back(t + LAT); qa_r.push_back(req); end
        if (rb) begin
            qb_v.push_back(vb);
            qb_t.push_back(ra ? t + 2 * LAT + 16 : t + LAT);
            qb_r.push_back(req);
        end
        wait_strobes(60);
    endtask

    task automatic measure_gap(output int g);
        @(negedge clk);
        while (!shift_en) @(negedge clk);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!shift_en);
    endtask

    initial begin
        #2000000;
        check(0, "R1", "watchdog expired", tk, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int g, nb, tdummy;
        for (int i = 0; i < 32; i++) mreg[i] = 8'h00;
        for (int i = 0; i < 2; i++) begin mcol[i] = 0; mbits[i] = 0; mstart[i] = 0; macc[i] = 0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R11: outputs quiet during and right after reset
        check(a_rsp_sync == 0 && a_rsp_sdo == 0, "R11", "port A response idle in reset", a_rsp_sync, 0);
        check(b_rsp_sync == 0 && b_rsp_sdo == 0, "R11", "port B response idle in reset", b_rsp_sync, 0);
        rst = 0;
        measure_gap(g);
        check(g == 1, "R1", "strobe spacing at rate 0", g, 1);

        // R11: storage cleared
        do_cmd(3'b010, 0, mk(0, 7'd3, 8'h00), 0, "R11");
        // R3/R2 basic writes and reads
        do_cmd(3'b110, 0, mk(1, 7'd3, 8'hA5), mk(1, 7'd7, 8'h3C), "R3");
        do_cmd(3'b110, 0, mk(0, 7'd3, 8'h00), mk(0, 7'd7, 8'h00), "R3");
        do_cmd(3'b001, mk(1, 7'd9, 8'h11), 0, 0, "R2");
        do_cmd(3'b100, 0, 0, mk(0, 7'd9, 8'hFF), "R2");
        // R5 priority
        do_cmd(3'b111, mk(1, 7'd12, 8'h01), mk(1, 7'd12, 8'h02), mk(1, 7'd12, 8'h03), "R5");
        do_cmd(3'b010, 0, mk(0, 7'd12, 8'h00), 0, "R5");
        do_cmd(3'b011, mk(1, 7'd13, 8'h44), mk(1, 7'd13, 8'h55), 0, "R5");
        do_cmd(3'b100, 0, 0, mk(0, 7'd13, 8'h00), "R5");
        // R4 identifier and unmapped regions
        do_cmd(3'b010, 0, mk(1, 7'h65, 8'hFF), 0, "R4");
        do_cmd(3'b010, 0, mk(0, 7'h65, 8'h00), 0, "R4");
        do_cmd(3'b100, 0, 0, mk(1, 7'h40, 8'h77), "R4");
        do_cmd(3'b100, 0, 0, mk(0, 7'h40, 8'h00), "R4");
        // R6 read on the W port: no response, nothing stored
        nb = n_resp;
        do_cmd(3'b001, mk(0, 7'd3, 8'h99), 0, 0, "R6");
        check(n_resp == nb, "R6", "responses after W-port read", n_resp - nb, 0);
        do_cmd(3'b010, 0, mk(0, 7'd3, 8'h00), 0, "R6");
        // R8 simultaneous reads on A and B
        do_cmd(3'b110, 0, mk(0, 7'd3, 8'h00), mk(0, 7'd7, 8'h00), "R8");
        // R10 read sees value before simultaneous write
        do_cmd(3'b011, mk(1, 7'd20, 8'h5A), mk(0, 7'd20, 8'h00), 0, "R10");
        do_cmd(3'b010, 0, mk(0, 7'd20, 8'h00), 0, "R10");
        // R9 partial word cut by new sync
        drive(3'b010, 0, mk(1, 7'd21, 8'hEE), 0, 8, tdummy);
        do_cmd(3'b010, 0, mk(1, 7'd22, 8'h33), 0, "R9");
        do_cmd(3'b110, 0, mk(0, 7'd21, 8'h00), mk(0, 7'd22, 8'h00), "R9");
        // R1 rate changes; R7 latency counted in strobes
        do_cmd(3'b010, 0, mk(1, 7'd0, 8'h01), 0, "R1");
        measure_gap(g);
        check(g == 2, "R1", "strobe spacing at rate 1", g, 2);
        do_cmd(3'b100, 0, 0, mk(0, 7'd3, 8'h00), "R7");
        do_cmd(3'b001, mk(1, 7'd0, 8'h02), 0, 0, "R1");
        measure_gap(g);
        check(g == 4, "R1", "strobe spacing at rate 2", g, 4);
        do_cmd(3'b010, 0, mk(0, 7'd7, 8'h00), 0, "R7");
        do_cmd(3'b100, 0, 0, mk(1, 7'd0, 8'h03), "R1");
        measure_gap(g);
        check(g == 4, "R1", "strobe spacing at rate 3", g, 4);
        do_cmd(3'b110, 0, mk(0, 7'd0, 8'h00), mk(0, 7'd12, 8'h00), "R8");

        check(qa_v.size() == 0, "R7", "port A responses outstanding", qa_v.size(), 0);
        check(qb_v.size() == 0, "R7", "port B responses outstanding", qb_v.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule